// File: doc/BRIEF.md
# I2C Master Byte-Transfer Sequencer

This block sits between a control register and a byte-level I2C bus engine. One accepted control write can start a master transfer of one to four bytes. The sequencer then works through the engine with a request/acknowledge handshake. It opens the bus with an address-and-direction start when the bus is idle, moves each byte, and closes the bus with a stop when the control bits ask for one. Write bytes are taken from a four-byte transmit word. Read bytes land in a four-byte receive buffer.

At the end of a sequence the block reports the number of completed bytes and the buffer index that follows from it. It raises error and aborted flags when the engine refuses an address or a byte. It can also raise an interrupt request on completion, or when a halt command closes a bus that was left open. A chained transfer leaves the bus held between control writes, and the next write carries on without a new start.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset, `ctrl_q`, `xfer_cnt`, `err`, `xfer_abort`, `irq` and `eng_req` are 0, `buf_idx` is 3'b111 (empty) and `seq_busy` is 0.
- R2: An accepted control write stores the written byte with bit 0 forced to 0 into `ctrl_q`. Setting bit 6 (wide-address select) is stored but has no effect: the engine always gets the 7-bit address `addr_lo[7:1]`.
- R3: A write with bit 0 set and no effective halt moves (bits 5:4)+1 bytes. On a write (bit 1 = 0), byte k is `tx_data[8k+7:8k]`, sent in order k = 0, 1, 2, 3.
- R4: Before each byte, if `bus_busy` is 0, a START request (`eng_op` = 0) is issued with `eng_addr` = `addr_lo[7:1]` and `eng_rd` = bit 1. If the bus is already held, no START is issued.
- R5: After each successful byte (`eng_op` = 1), a STOP (`eng_op` = 2) is issued if bit 3 is set or bit 2 is clear. Otherwise the bus is left held.
- R6: A START answered with `eng_nack` sets `err` and `xfer_abort`, moves no data byte, and ends the sequence with `xfer_cnt` = 0.
- R7: A data byte answered with `eng_nack` sets `err` and `xfer_abort` and ends the sequence at once, with no STOP. `xfer_cnt` equals the bytes completed before it.
- R8: A START acknowledged without nack clears `err`. `xfer_abort` stays set until reset.
- R9: At the end of a sequence, `xfer_cnt` holds the completed byte count and `buf_idx` holds that count minus one (3'b111 for zero). On a read, byte k returned by the engine is stored in `rx_data[8k+7:8k]`.
- R10: A control write with bit 7 set while `bus_busy` is 1 issues only a STOP, even if bit 0 is set. When the STOP completes, `irq` is raised if `irq_en` and `irq_mask_halt` are both 1. With the bus idle, bit 7 does nothing.
- R11: When a sequence ends with at least one completed byte, `irq` is raised if `irq_en` and `irq_mask_done` are both 1. When no byte completed, `irq` is not raised.
- R12: `eng_req` stays high with `eng_op` unchanged until the cycle in which `eng_ack` is seen.
- R13: A control write while `seq_busy` is 1 is ignored: `ctrl_q` is unchanged and no extra transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_wdata | input | 8 | Control byte written |
| addr_lo | input | 7 | Bits 7:1 of the low address register |
| tx_data | input | 32 | Four transmit bytes, byte k at bits 8k+7:8k |
| irq_en | input | 1 | Global interrupt enable |
| irq_mask_done | input | 1 | Completion interrupt mask bit |
| irq_mask_halt | input | 1 | Halt interrupt mask bit |
| bus_busy | input | 1 | Engine reports bus held |
| eng_ack | input | 1 | Engine finished current request |
| eng_nack | input | 1 | Engine failure, valid with eng_ack |
| eng_rdata | input | 8 | Byte read by the engine, valid with eng_ack |
| eng_req | output | 1 | Request to the engine |
| eng_op | output | 2 | 0 START, 1 data byte, 2 STOP |
| eng_addr | output | 7 | Target address for START |
| eng_rd | output | 1 | Direction: 1 read |
| eng_wdata | output | 8 | Byte to send |
| ctrl_q | output | 8 | Stored control value |
| seq_busy | output | 1 | Sequence or halt in progress |
| xfer_cnt | output | 3 | Completed byte count |
| buf_idx | output | 3 | Buffer index, count minus one |
| rx_data | output | 32 | Receive buffer |
| err | output | 1 | Error flag |
| xfer_abort | output | 1 | Transfer aborted flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the engine answers each request with a single-cycle `eng_ack`, and that `eng_nack` is meaningful only in that cycle. They also assume that `bus_busy` changes only at the edge where a START or STOP is acknowledged, so a START is never in flight while the bus is held. The bench engine model follows these rules exactly. It answers one cycle after a request, updates its busy state at the same edge as the acknowledge, and refuses an address or byte only when a scenario arms it. Control writes are driven on the falling edge so that they never race the sequencer's state change.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  // control word bit positions (decoded by the sequencer)
  localparam int CB_GO    = 0;
  localparam int CB_RD    = 1;
  localparam int CB_CHAIN = 2;
  localparam int CB_RPT   = 3;
  localparam int CB_LEN   = 4;
  localparam int CB_HALT  = 7;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_DATA  = 2'd1,
    OP_STOP  = 2'd2
  } eng_op_t;

  typedef enum logic [2:0] {
    S_IDLE, S_LAUNCH, S_START, S_DATA, S_STOP, S_HSTOP, S_FIN
  } seq_st_t;
endpackage

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
  import i2c_seq_pkg::*;
#(
  parameter int CW   = 3,
  parameter int LENW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  input  logic            halt,
  input  logic            rd_in,
  input  logic            stop_each_in,
  input  logic [LENW-1:0] last_in,
  input  logic            bus_busy,
  input  logic            eng_ack,
  input  logic            eng_nack,
  output logic            eng_req,
  output eng_op_t         eng_op,
  output logic            rd_q,
  output logic [CW-1:0]   idx_q,
  output logic            busy,
  output logic            fin,
  output logic            halt_done,
  output logic            start_ok,
  output logic            fail,
  output logic            byte_ok
);
  timeunit 1ns;
  timeprecision 100ps;

  seq_st_t         st_q, st_d;
  logic [CW-1:0]   idx_d;
  logic [LENW-1:0] last_q;
  logic            se_q;
  logic            idx_en, cfg_en;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    cfg_en  = 1'b0;
    eng_req = 1'b0;
    eng_op  = OP_START;
    case (st_q)
      S_IDLE: begin
        if (launch) begin
          st_d   = S_LAUNCH;
          idx_d  = '0;
          idx_en = 1'b1;
          cfg_en = 1'b1;
        end else if (halt) begin
          st_d = S_HSTOP;
        end
      end
      S_LAUNCH: begin
        if (idx_q > CW'(last_q)) st_d = S_FIN;
        else if (!bus_busy)      st_d = S_START;
        else                     st_d = S_DATA;
      end
      S_START: begin
        eng_req = 1'b1;
        eng_op  = OP_START;
        if (eng_ack) st_d = eng_nack ? S_FIN : S_DATA;
      end
      S_DATA: begin
        eng_req = 1'b1;
        eng_op  = OP_DATA;
        if (eng_ack) begin
          if (eng_nack) begin
            st_d = S_FIN;
          end else begin
            idx_d  = idx_q + 1'b1;
            idx_en = 1'b1;
            st_d   = se_q ? S_STOP : S_LAUNCH;
          end
        end
      end
      S_STOP: begin
        eng_req = 1'b1;
        eng_op  = OP_STOP;
        if (eng_ack) st_d = S_LAUNCH;
      end
      S_HSTOP: begin
        eng_req = 1'b1;
        eng_op  = OP_STOP;
        if (eng_ack) st_d = S_IDLE;
      end
      S_FIN:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      se_q   <= 1'b0;
      last_q <= '0;
    end else if (cfg_en) begin
      rd_q   <= rd_in;
      se_q   <= stop_each_in;
      last_q <= last_in;
    end
  end

  assign busy      = (st_q != S_IDLE);
  assign fin       = (st_q == S_FIN);
  assign halt_done = (st_q == S_HSTOP) && eng_ack;
  assign start_ok  = (st_q == S_START) && eng_ack && !eng_nack;
  assign fail      = ((st_q == S_START) || (st_q == S_DATA)) && eng_ack && eng_nack;
  assign byte_ok   = (st_q == S_DATA) && eng_ack && !eng_nack;

  // R12: request and operation held until acknowledged
  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && !eng_ack |=> eng_req && $stable(eng_op));

  // R4: a START is only requested while the bus is free
  p_start_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && eng_op == OP_START |-> !bus_busy || eng_ack);

  // R5: stop follows a good byte when stop-per-byte was latched
  p_stop_after_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ok && se_q |=> eng_req && eng_op == OP_STOP);

  // R5: no stop follows a good byte on a held chain
  p_hold_chain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ok && !se_q |=> !(eng_req && eng_op == OP_STOP));

  // R9: completed count never exceeds programmed length
  p_fin_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> idx_q <= CW'(last_q) + 1'b1);
endmodule

// File: rtl/i2c_seq_rxbuf.sv
module i2c_seq_rxbuf #(
  parameter int NBYTES = 4,
  parameter int BW     = 8,
  parameter int CW     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [CW-1:0]        wr_idx,
  input  logic [BW-1:0]        wr_data,
  output logic [NBYTES*BW-1:0] rx_flat
);
  timeunit 1ns;
  timeprecision 100ps;

  for (genvar g = 0; g < NBYTES; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en && (wr_idx == CW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rx_flat[g*BW +: BW] <= '0;
      end else if (slot_en) begin
        rx_flat[g*BW +: BW] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/i2c_seq_status.sv
module i2c_seq_status #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fin,
  input  logic [CW-1:0] done_cnt,
  input  logic          fail,
  input  logic          start_ok,
  input  logic          halt_done,
  input  logic          irq_en,
  input  logic          irq_mask_done,
  input  logic          irq_mask_halt,
  output logic          err,
  output logic          aborted,
  output logic [CW-1:0] xfer_cnt,
  output logic [CW-1:0] buf_idx,
  output logic          irq
);
  timeunit 1ns;
  timeprecision 100ps;

  logic err_d, abort_d, irq_set;

  always_comb begin
    err_d   = err;
    abort_d = aborted;
    if (start_ok) err_d = 1'b0;
    if (fail) begin
      err_d   = 1'b1;
      abort_d = 1'b1;
    end
    irq_set = irq_en && ((fin && done_cnt != '0 && irq_mask_done) ||
                         (halt_done && irq_mask_halt));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err     <= 1'b0;
      aborted <= 1'b0;
    end else begin
      err     <= err_d;
      aborted <= abort_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_cnt <= '0;
      buf_idx  <= '1;
    end else if (fin) begin
      xfer_cnt <= done_cnt;
      buf_idx  <= done_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else if (irq_set) begin
      irq <= 1'b1;
    end
  end

  // R11: completion with bytes and enables raises the request
  p_irq_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fin && done_cnt != '0 && irq_en && irq_mask_done |=> irq);

  // R6: an engine refusal leaves both failure flags set
  p_fail_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> err && aborted);

  // R8: good start clears the error flag
  p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> !err);
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
  import i2c_seq_pkg::*;
#(
  parameter int NBYTES = 4,
  parameter int BW     = 8,
  parameter int AW     = 7,
  localparam int CW    = $clog2(NBYTES + 1),
  localparam int LENW  = $clog2(NBYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctrl_wr,
  input  logic [7:0]           ctrl_wdata,
  input  logic [AW:1]          addr_lo,
  input  logic [NBYTES*BW-1:0] tx_data,
  input  logic                 irq_en,
  input  logic                 irq_mask_done,
  input  logic                 irq_mask_halt,
  input  logic                 bus_busy,
  input  logic                 eng_ack,
  input  logic                 eng_nack,
  input  logic [BW-1:0]        eng_rdata,
  output logic                 eng_req,
  output logic [1:0]           eng_op,
  output logic [AW-1:0]        eng_addr,
  output logic                 eng_rd,
  output logic [BW-1:0]        eng_wdata,
  output logic [7:0]           ctrl_q,
  output logic                 seq_busy,
  output logic [CW-1:0]        xfer_cnt,
  output logic [CW-1:0]        buf_idx,
  output logic [NBYTES*BW-1:0] rx_data,
  output logic                 err,
  output logic                 xfer_abort,
  output logic                 irq
);
  timeunit 1ns;
  timeprecision 100ps;

  logic          wr_ok, launch, halt, ctrl_en;
  logic [7:0]    ctrl_d;
  eng_op_t       op_w;
  logic [CW-1:0] idx_w;
  logic          fin_w, hdone_w, sok_w, fail_w, bok_w;

  assign wr_ok   = ctrl_wr && !seq_busy;
  assign halt    = wr_ok && ctrl_wdata[CB_HALT] && bus_busy;
  assign launch  = wr_ok && ctrl_wdata[CB_GO] && !halt;
  assign ctrl_en = wr_ok;
  assign ctrl_d  = {ctrl_wdata[7:1], 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  i2c_seq_fsm #(.CW(CW), .LENW(LENW)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch       (launch),
    .halt         (halt),
    .rd_in        (ctrl_wdata[CB_RD]),
    .stop_each_in (ctrl_wdata[CB_RPT] || !ctrl_wdata[CB_CHAIN]),
    .last_in      (ctrl_wdata[CB_LEN +: LENW]),
    .bus_busy     (bus_busy),
    .eng_ack      (eng_ack),
    .eng_nack     (eng_nack),
    .eng_req      (eng_req),
    .eng_op       (op_w),
    .rd_q         (eng_rd),
    .idx_q        (idx_w),
    .busy         (seq_busy),
    .fin          (fin_w),
    .halt_done    (hdone_w),
    .start_ok     (sok_w),
    .fail         (fail_w),
    .byte_ok      (bok_w)
  );

  assign eng_op    = op_w;
  assign eng_addr  = addr_lo;
  assign eng_wdata = tx_data[idx_w[LENW-1:0]*BW +: BW];

  i2c_seq_rxbuf #(.NBYTES(NBYTES), .BW(BW), .CW(CW)) u_rxbuf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bok_w && eng_rd),
    .wr_idx  (idx_w),
    .wr_data (eng_rdata),
    .rx_flat (rx_data)
  );

  i2c_seq_status #(.CW(CW)) u_status (
    .clk           (clk),
    .rst_n         (rst_n),
    .fin           (fin_w),
    .done_cnt      (idx_w),
    .fail          (fail_w),
    .start_ok      (sok_w),
    .halt_done     (hdone_w),
    .irq_en        (irq_en),
    .irq_mask_done (irq_mask_done),
    .irq_mask_halt (irq_mask_halt),
    .err           (err),
    .aborted       (xfer_abort),
    .xfer_cnt      (xfer_cnt),
    .buf_idx       (buf_idx),
    .irq           (irq)
  );

  // R13: a control write during a sequence leaves the stored value alone
  p_ctrl_ignored_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && seq_busy |=> $stable(ctrl_q));

  // R10: a halt on a held bus never opens a transfer
  p_halt_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !seq_busy && ctrl_wdata[CB_HALT] && bus_busy |=>
      seq_busy && !(eng_req && eng_op != 2'(OP_STOP)));
endmodule

// File: tb/i2c_xfer_seq_tb.sv
module i2c_xfer_seq_tb;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctrl_wr;
  logic [7:0]  ctrl_wdata;
  logic [7:0]  addr_reg;
  logic [31:0] tx_data;
  logic        irq_en, irq_mask_done, irq_mask_halt;
  logic        bus_busy, eng_ack, eng_nack;
  logic [7:0]  eng_rdata;
  logic        eng_req, eng_rd, seq_busy, err, xfer_abort, irq;
  logic [1:0]  eng_op;
  logic [6:0]  eng_addr;
  logic [7:0]  eng_wdata, ctrl_q;
  logic [2:0]  xfer_cnt, buf_idx;
  logic [31:0] rx_data;

  int n_vec = 0;
  int n_bad = 0;

  // engine model state and logs
  int         n_start = 0, n_stop = 0, n_data = 0, n_viol = 0;
  logic       nack_start = 1'b0;
  int         nack_at = -1;
  logic [6:0] last_addr = '0;
  logic       last_rd = 1'b0;
  logic [7:0] wlog [0:255];
  logic       pend = 1'b0;
  logic [1:0] pend_op = '0;

  always #2.5 clk = ~clk;

  i2c_xfer_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .addr_lo(addr_reg[7:1]), .tx_data(tx_data), .irq_en(irq_en),
    .irq_mask_done(irq_mask_done), .irq_mask_halt(irq_mask_halt),
    .bus_busy(bus_busy), .eng_ack(eng_ack), .eng_nack(eng_nack),
    .eng_rdata(eng_rdata), .eng_req(eng_req), .eng_op(eng_op),
    .eng_addr(eng_addr), .eng_rd(eng_rd), .eng_wdata(eng_wdata),
    .ctrl_q(ctrl_q), .seq_busy(seq_busy), .xfer_cnt(xfer_cnt),
    .buf_idx(buf_idx), .rx_data(rx_data), .err(err),
    .xfer_abort(xfer_abort), .irq(irq)
  );

  // byte-level engine model: answers one cycle after a request
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_ack  <= 1'b0;
      eng_nack <= 1'b0;
      bus_busy <= 1'b0;
      eng_rdata <= '0;
      pend     <= 1'b0;
    end else if (eng_req && !eng_ack) begin
      if (pend && pend_op != eng_op) n_viol <= n_viol + 1;
      pend    <= 1'b1;
      pend_op <= eng_op;
      eng_ack <= 1'b1;
      case (eng_op)
        2'd0: begin
          n_start   <= n_start + 1;
          last_addr <= eng_addr;
          last_rd   <= eng_rd;
          eng_nack  <= nack_start;
          if (!nack_start) bus_busy <= 1'b1;
        end
        2'd1: begin
          eng_nack  <= (n_data == nack_at);
          eng_rdata <= 8'hA0 + n_data[7:0];
          wlog[n_data[7:0]] <= eng_wdata;
          n_data    <= n_data + 1;
        end
        default: begin
          n_stop   <= n_stop + 1;
          eng_nack <= 1'b0;
          bus_busy <= 1'b0;
        end
      endcase
    end else begin
      eng_ack  <= 1'b0;
      eng_nack <= 1'b0;
      pend     <= 1'b0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ctrl_wr = 1'b0;
    ctrl_wdata = '0;
    nack_start = 1'b0;
    nack_at = -1;
    irq_en = 1'b0;
    irq_mask_done = 1'b0;
    irq_mask_halt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic write_ctrl(input logic [7:0] v);
    ctrl_wdata = v;
    ctrl_wr = 1'b1;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic wait_idle();
    while (seq_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(input logic [7:0] v);
    write_ctrl(v);
    wait_idle();
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 ctrl_q", ctrl_q, 0);
    check("R1 xfer_cnt", xfer_cnt, 0);
    check("R1 buf_idx", buf_idx, 3'b111);
    check("R1 flags", {err, xfer_abort, irq, eng_req, seq_busy}, 0);
  endtask

  task automatic t_write4();
    int s0, p0, d0;
    do_reset();
    s0 = n_start; p0 = n_stop; d0 = n_data;
    run(8'h31);
    check("R2 ctrl_q", ctrl_q, 8'h30);
    check("R5 starts", n_start - s0, 4);
    check("R5 stops", n_stop - p0, 4);
    check("R3 bytes", n_data - d0, 4);
    for (int k = 0; k < 4; k++)
      check("R3 byte order", wlog[8'(d0 + k)], tx_data[8*k +: 8]);
    check("R4 addr", last_addr, addr_reg[7:1]);
    check("R4 dir", last_rd, 0);
    check("R9 count", xfer_cnt, 4);
    check("R9 index", buf_idx, 3);
    check("R11 no irq when disabled", irq, 0);
  endtask

  task automatic t_read_chain_halt();
    int s0, p0, d0;
    do_reset();
    s0 = n_start; p0 = n_stop; d0 = n_data;
    run(8'h17);
    check("R5 held chain stops", n_stop - p0, 0);
    check("R4 one start", n_start - s0, 1);
    check("R4 read dir", last_rd, 1);
    check("R9 rx byte0", rx_data[7:0], 8'hA0 + 8'(d0));
    check("R9 rx byte1", rx_data[15:8], 8'hA0 + 8'(d0 + 1));
    check("R9 read count", xfer_cnt, 2);
    check("R9 read index", buf_idx, 1);
    check("R5 bus held", bus_busy, 1);
    run(8'h07);
    check("R4 no start on held bus", n_start - s0, 1);
    check("R9 chained rx", rx_data[7:0], 8'hA0 + 8'(d0 + 2));
    check("R9 chained count", xfer_cnt, 1);
    irq_en = 1'b1; irq_mask_halt = 1'b1;
    run(8'h81);
    check("R10 halt stop", n_stop - p0, 1);
    check("R10 halt no start", n_start - s0, 1);
    check("R10 halt no data", n_data - d0, 3);
    check("R10 halt irq", irq, 1);
    check("R10 bus released", bus_busy, 0);
    check("R2 halt stored", ctrl_q, 8'h80);
  endtask

  task automatic t_rpst();
    int s0, p0;
    do_reset();
    s0 = n_start; p0 = n_stop;
    run(8'h2D);
    check("R5 rpst starts", n_start - s0, 3);
    check("R5 rpst stops", n_stop - p0, 3);
    check("R9 rpst count", xfer_cnt, 3);
  endtask

  task automatic t_start_nack();
    int s0, d0;
    do_reset();
    irq_en = 1'b1; irq_mask_done = 1'b1;
    nack_start = 1'b1;
    s0 = n_start; d0 = n_data;
    run(8'h01);
    check("R6 start attempted", n_start - s0, 1);
    check("R6 no data", n_data - d0, 0);
    check("R6 err", err, 1);
    check("R6 abort", xfer_abort, 1);
    check("R6 count", xfer_cnt, 0);
    check("R9 empty index", buf_idx, 3'b111);
    check("R11 no irq at zero", irq, 0);
    nack_start = 1'b0;
    run(8'h01);
    check("R8 err cleared", err, 0);
    check("R8 abort sticky", xfer_abort, 1);
    check("R11 done irq", irq, 1);
  endtask

  task automatic t_data_nack();
    int p0, d0;
    do_reset();
    d0 = n_data; p0 = n_stop;
    nack_at = d0 + 2;
    run(8'h31);
    check("R7 attempts", n_data - d0, 3);
    check("R7 stops", n_stop - p0, 2);
    check("R7 count", xfer_cnt, 2);
    check("R9 index", buf_idx, 1);
    check("R7 flags", {err, xfer_abort}, 2'b11);
    check("R7 bus left held", bus_busy, 1);
  endtask

  task automatic t_wide_and_idle_halt();
    int p0, s0;
    do_reset();
    run(8'h41);
    check("R2 wide stored", ctrl_q, 8'h40);
    check("R2 addr 7-bit", last_addr, addr_reg[7:1]);
    check("R2 wide count", xfer_cnt, 1);
    irq_en = 1'b1; irq_mask_halt = 1'b1;
    p0 = n_stop; s0 = n_start;
    run(8'h80);
    check("R10 idle halt no stop", n_stop - p0, 0);
    check("R10 idle halt no start", n_start - s0, 0);
    check("R10 idle halt no irq", irq, 0);
  endtask

  task automatic t_ignore();
    int d0;
    do_reset();
    d0 = n_data;
    write_ctrl(8'h31);
    @(negedge clk);
    write_ctrl(8'h0F);
    wait_idle();
    repeat (4) @(negedge clk);
    check("R13 ctrl_q kept", ctrl_q, 8'h30);
    check("R13 no extra bytes", n_data - d0, 4);
    check("R13 count", xfer_cnt, 4);
    check("R12 op stable", n_viol, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    addr_reg = 8'hA5;
    tx_data  = 32'h44332211;
    t_reset();
    t_write4();
    t_read_chain_halt();
    t_rpst();
    t_start_nack();
    t_data_nack();
    t_wide_and_idle_halt();
    t_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule